// File: doc/BRIEF.md
# Two-Channel Pulse-Width Modulator with Table Prescaler

This block generates two independent pulse-width modulated outputs. Each channel first slows the module clock with a prescaler whose ratio is taken from a fixed, sparse table of non-power-of-two values. A period counter then runs over the slowed ticks, and the output sits at its active level for a programmed number of ticks at the start of every period. Software configures the block through a plain word-addressed register port: one shared control word and one period/duty word for each channel.

New period/duty words first land in a shadow copy. The running counter picks them up only when its current period ends, or at once when the channel is stopped. While a value waits, a busy flag in the control word is raised. Each channel also has a bypass mode that sends the raw module clock straight to its pin and overrides every other setting.

The register port is simple control access, so it has no valid/ready handshake. A write takes effect at the clock edge on which `bus_wr` is high. Reads are combinational from `bus_addr`.

Top module: `twin_pwm`

## Requirements
- R1: While reset is asserted both outputs are low. After reset the control word and both period words read 0, and both busy flags read 0.
- R2: The control word sits at byte address 0x0 and holds one field per channel, starting at bit 15·ch. Within a field:
  - bits [3:0] are the prescaler code,
  - bit 4 is enable,
  - bit 5 is active level,
  - bit 6 is clock gate,
  - bit 9 is bypass.
  All other field bits read 0. Bit 28+ch is a read-only busy flag.
- R3: The prescaler ratios are:
  - codes 0..4 give 120, 180, 240, 360 and 480,
  - codes 8..12 give 12000, 24000, 36000, 48000 and 72000,
  - code 15 gives 1.
- R4: Codes 5..7, 13 and 14 are invalid. With an invalid code the tick stops, the counter holds, and the output stays at the inactive level.
- R5: The period word of channel ch sits at byte address 0x4+4·ch, and a read returns the last value written. Bits [31:16] hold N−1 and bits [15:0] hold D. With prescaler ratio r, the output repeats every (N)·r clocks and is active for D·r clocks of each repeat.
- R6: A channel produces a waveform only when enable and clock gate are both 1. Otherwise its output rests at the inactive level.
- R7: Active level 1 means the output is high while active and low while inactive. Active level 0 inverts both.
- R8: D = 0 gives a constant inactive output. D ≥ N gives a constant active output.
- R9: A period-word write to a running channel takes effect at the end of the current period. A write to a stopped channel takes effect on the next clock. The busy flag reads 1 from the write until the value takes effect.
- R10: If a period-word write lands on the same clock edge as a period end, that period end loads the older value. The new value stays pending, with busy still 1, until the following period end.
- R11: With bypass set, the output equals the module clock, whatever the enable, gate, prescaler and period settings. Clearing bypass returns the pin to the waveform logic at once.
- R12: The two channels run independently. Each has its own timing and busy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pwm_out | output | 2 | Channel outputs, bit ch for channel ch |

## Verification
The two functions that can fall in the same cycle are a software write to the period word and the period-end reload of the running counter from the shadow copy. The bench finds the output's rising edge to learn the counter's phase. It then times a write so that the write strobe meets exactly the wrap edge of a divide-by-1 channel. It judges the result by three observations:
- the busy flag still reads 1 right after that edge,
- the next full period still has the old length and duty,
- the period after that has the new ones.

// File: rtl/twin_pwm_pkg.sv
package twin_pwm_pkg;
  localparam int PSC_W = 4;
  localparam int DIV_W = 17;

  typedef struct packed {
    logic             bypass;
    logic             gate;
    logic             pol;
    logic             en;
    logic [PSC_W-1:0] psc;
  } ch_ctrl_t;

  // Ratio for a prescaler code; 0 marks an unusable code.
  function automatic logic [DIV_W-1:0] div_ratio(input logic [PSC_W-1:0] code,
                                                  input bit div1_ok);
    case (code)
      4'd0:    div_ratio = DIV_W'(120);
      4'd1:    div_ratio = DIV_W'(180);
      4'd2:    div_ratio = DIV_W'(240);
      4'd3:    div_ratio = DIV_W'(360);
      4'd4:    div_ratio = DIV_W'(480);
      4'd8:    div_ratio = DIV_W'(12000);
      4'd9:    div_ratio = DIV_W'(24000);
      4'd10:   div_ratio = DIV_W'(36000);
      4'd11:   div_ratio = DIV_W'(48000);
      4'd12:   div_ratio = DIV_W'(72000);
      4'd15:   div_ratio = div1_ok ? DIV_W'(1) : '0;
      default: div_ratio = '0;
    endcase
  endfunction
endpackage

// File: rtl/twin_pwm_prescaler.sv
module twin_pwm_prescaler
  import twin_pwm_pkg::*;
#(
  parameter bit HAS_DIV1 = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] code,
  output logic             valid,
  output logic             tick
);
  logic [DIV_W-1:0] ratio;
  logic [DIV_W-1:0] cnt_q;

  assign ratio = div_ratio(code, HAS_DIV1);
  assign valid = (ratio != '0);
  assign tick  = run && valid && (cnt_q >= ratio - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (valid)   cnt_q <= tick ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/twin_pwm_channel.sv
module twin_pwm_channel #(
  parameter int CNT_W = 16,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              valid,
  input  logic              tick,
  input  logic              pol,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] shadow,
  output logic              busy,
  output logic              wave
);
  logic [WORD_W-1:0] shadow_q;
  logic              pend_q;
  logic [CNT_W-1:0]  prd_q, dty_q, cnt_q;
  logic              wave_q;
  logic              wrap, load;

  assign wrap = tick && (cnt_q == prd_q);
  assign load = pend_q && (!run || wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      pend_q   <= 1'b0;
      prd_q    <= '0;
      dty_q    <= '0;
      cnt_q    <= '0;
      wave_q   <= 1'b0;
    end else begin
      if (wr) shadow_q <= wdata;
      // A write wins over a simultaneous reload: the reload uses the older word.
      if (wr)        pend_q <= 1'b1;
      else if (load) pend_q <= 1'b0;
      if (load) begin
        prd_q <= shadow_q[WORD_W-1 -: CNT_W];
        dty_q <= shadow_q[CNT_W-1:0];
      end
      if (!run)      cnt_q <= '0;
      else if (tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      wave_q <= (run && valid && (cnt_q < dty_q)) ? pol : !pol;
    end
  end

  assign shadow = shadow_q;
  assign busy   = pend_q;
  assign wave   = wave_q;

  p_busy_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> busy);
  p_busy_idle_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !run && !wr) |=> !busy);
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= prd_q);
  p_freeze_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !valid) |=> $stable(cnt_q));
  p_no_tick_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !tick);
  p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (wave == !$past(pol)));
endmodule

// File: rtl/twin_pwm.sv
module twin_pwm
  import twin_pwm_pkg::*;
#(
  parameter int  NUM_CH   = 2,
  parameter int  ADDR_W   = 4,
  parameter int  WORD_W   = 32,
  parameter int  CNT_W    = 16,
  parameter bit  HAS_DIV1 = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int STRIDE    = 15;
  localparam int BUSY_BASE = 28;
  localparam int B_EN      = 4;
  localparam int B_POL     = 5;
  localparam int B_GATE    = 6;
  localparam int B_BYP     = 9;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

  ch_ctrl_t          ctrl_q [NUM_CH];
  logic [WORD_W-1:0] shadow [NUM_CH];
  logic [NUM_CH-1:0] busy;
  logic              ctrl_wr;

  assign ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) ctrl_q[c] <= '0;
    end else if (ctrl_wr) begin
      for (int c = 0; c < NUM_CH; c++) begin
        ctrl_q[c].psc    <= bus_wdata[c*STRIDE +: PSC_W];
        ctrl_q[c].en     <= bus_wdata[c*STRIDE + B_EN];
        ctrl_q[c].pol    <= bus_wdata[c*STRIDE + B_POL];
        ctrl_q[c].gate   <= bus_wdata[c*STRIDE + B_GATE];
        ctrl_q[c].bypass <= bus_wdata[c*STRIDE + B_BYP];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_ADDR) begin
      for (int c = 0; c < NUM_CH; c++) begin
        bus_rdata[c*STRIDE +: PSC_W]   = ctrl_q[c].psc;
        bus_rdata[c*STRIDE + B_EN]     = ctrl_q[c].en;
        bus_rdata[c*STRIDE + B_POL]    = ctrl_q[c].pol;
        bus_rdata[c*STRIDE + B_GATE]   = ctrl_q[c].gate;
        bus_rdata[c*STRIDE + B_BYP]    = ctrl_q[c].bypass;
        bus_rdata[BUSY_BASE + c]       = busy[c];
      end
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr == ADDR_W'(4 + 4*c)) bus_rdata = shadow[c];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic run, valid, tick, wave, per_wr;

    assign run    = ctrl_q[g].en && ctrl_q[g].gate && !ctrl_q[g].bypass;
    assign per_wr = bus_wr && (bus_addr == ADDR_W'(4 + 4*g));

    twin_pwm_prescaler #(.HAS_DIV1(HAS_DIV1)) u_psc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .code  (ctrl_q[g].psc),
      .valid (valid),
      .tick  (tick)
    );

    twin_pwm_channel #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .valid  (valid),
      .tick   (tick),
      .pol    (ctrl_q[g].pol),
      .wr     (per_wr),
      .wdata  (bus_wdata),
      .shadow (shadow[g]),
      .busy   (busy[g]),
      .wave   (wave)
    );

    // Bypass hands the raw module clock to the pin, overriding the waveform.
    assign pwm_out[g] = ctrl_q[g].bypass ? clk : wave;
  end
endmodule

// File: tb/twin_pwm_tb.sv
module twin_pwm_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  pwm_out;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  twin_pwm u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [14:0] fld(input int psc, input bit en, input bit pol,
                                      input bit gate, input bit byp);
    fld = 15'(psc) | (15'(en) << 4) | (15'(pol) << 5) | (15'(gate) << 6) | (15'(byp) << 9);
  endfunction

  // Called right after a falling edge; the write lands on the next rising edge.
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // Time at level lvl and full repeat length, measured from an entry into lvl.
  task automatic measure(input int ch, input logic lvl, output int act, output int per);
    logic prev, cur;
    int guard;
    bit hit;
    prev = pwm_out[ch]; guard = 0; hit = 1'b0;
    while (!hit && guard < 100000) begin
      @(negedge clk); cur = pwm_out[ch];
      hit = (cur == lvl) && (prev != lvl); prev = cur; guard++;
    end
    act = 1; per = 1; hit = 1'b0;
    while (!hit && per < 100000) begin
      @(negedge clk); cur = pwm_out[ch];
      if (cur == lvl && prev != lvl) hit = 1'b1;
      else begin per++; if (cur == lvl) act++; end
      prev = cur;
    end
  endtask

  task automatic hold_level(input int ch, input logic lvl, input int n, input string tag);
    bit ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); if (pwm_out[ch] !== lvl) ok = 1'b0;
    end
    check(ok, tag, pwm_out[ch], lvl);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    repeat (3) @(negedge clk);
    check(pwm_out == 2'b00, "R1 outputs low in reset", pwm_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'h0, d); check(d == 0, "R1 control after reset", d, 0);
    rd(4'h4, d); check(d == 0, "R1 period0 after reset", d, 0);
    rd(4'h8, d); check(d == 0, "R1 period1 after reset", d, 0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d); check(d == 32'h013F_827F, "R2 control field layout", d, 32'h013F_827F);
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h0003_0001);
    rd(4'h4, d); check(d == 32'h0003_0001, "R5 period word readback", d, 32'h0003_0001);
  endtask

  task automatic run_ch0(input int psc, input bit pol, input logic [31:0] per_word);
    wr(4'h0, 32'h0);
    wr(4'h4, per_word);
    @(negedge clk);
    wr(4'h0, 32'(fld(psc, 1, pol, 1, 0)));
  endtask

  task automatic t_div(input int psc, input int ratio);
    int a, p;
    run_ch0(psc, 1, 32'h0001_0001);
    measure(0, 1'b1, a, p);
    check(a == ratio && p == 2*ratio, $sformatf("R3 code %0d active", psc), a, ratio);
    check(p == 2*ratio, $sformatf("R3 code %0d period", psc), p, 2*ratio);
  endtask

  task automatic t_basic();
    int a, p;
    run_ch0(15, 1, 32'h0004_0002);
    measure(0, 1'b1, a, p);
    check(a == 2, "R5 active clocks div1", a, 2);
    check(p == 5, "R5 period clocks div1", p, 5);
  endtask

  task automatic t_invalid();
    run_ch0(5, 1, 32'h0004_0002);
    hold_level(0, 1'b0, 300, "R4 invalid code 5 inactive");
    run_ch0(13, 0, 32'h0004_0002);
    hold_level(0, 1'b1, 300, "R4 invalid code 13 inactive");
  endtask

  task automatic t_gate();
    wr(4'h0, 32'(fld(15, 1, 1, 0, 0)));
    hold_level(0, 1'b0, 40, "R6 enable without gate");
    wr(4'h0, 32'(fld(15, 0, 1, 1, 0)));
    hold_level(0, 1'b0, 40, "R6 gate without enable");
    wr(4'h0, 32'(fld(15, 0, 0, 1, 0)));
    hold_level(0, 1'b1, 40, "R7 idle high for active-low");
  endtask

  task automatic t_pol();
    int a, p;
    run_ch0(15, 0, 32'h0004_0002);
    measure(0, 1'b0, a, p);
    check(a == 2 && p == 5, "R7 active-low low time", a, 2);
  endtask

  task automatic t_duty_edges();
    run_ch0(15, 1, 32'h0004_0000);
    hold_level(0, 1'b0, 40, "R8 duty 0 inactive");
    run_ch0(15, 1, 32'h0004_0007);
    repeat (2) @(negedge clk);
    hold_level(0, 1'b1, 40, "R8 duty over period active");
  endtask

  task automatic t_shadow();
    logic [31:0] d;
    int a, p, n;
    run_ch0(15, 1, 32'h0004_0002);
    repeat (12) @(negedge clk);
    wr(4'h4, 32'h0009_0003);
    rd(4'h0, d); check(d[28] == 1'b1, "R9 busy after running write", d[28], 1);
    n = 0;
    while (d[28] && n < 50) begin @(negedge clk); rd(4'h0, d); n++; end
    check(n <= 5, "R9 busy clears by period end", n, 5);
    measure(0, 1'b1, a, p);
    check(a == 3 && p == 10, "R9 new word after reload", a, 3);
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h0004_0001);
    rd(4'h0, d); check(d[28] == 1'b1, "R9 busy after idle write", d[28], 1);
    @(negedge clk);
    rd(4'h0, d); check(d[28] == 1'b0, "R9 idle reload next clock", d[28], 0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    logic prev, cur;
    int a, p, guard;
    run_ch0(15, 1, 32'h0007_0003);
    repeat (20) @(negedge clk);
    prev = pwm_out[0]; guard = 0;
    forever begin
      @(negedge clk); cur = pwm_out[0]; guard++;
      if ((cur && !prev) || guard > 100) break;
      prev = cur;
    end
    repeat (6) @(negedge clk);
    wr(4'h4, 32'h0003_0001);
    rd(4'h0, d); check(d[28] == 1'b1, "R10 busy kept on collision", d[28], 1);
    measure(0, 1'b1, a, p);
    check(a == 3 && p == 8, "R10 old word for next period", p, 8);
    measure(0, 1'b1, a, p);
    check(a == 1 && p == 4, "R10 new word one period later", p, 4);
  endtask

  task automatic t_bypass();
    bit ok = 1'b1;
    wr(4'h0, 32'(fld(5, 0, 0, 0, 1)));
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #2; if (pwm_out[0] !== 1'b1) ok = 1'b0;
      @(negedge clk); #2; if (pwm_out[0] !== 1'b0) ok = 1'b0;
    end
    check(ok, "R11 bypass follows clock", pwm_out[0], 0);
    @(negedge clk);
    wr(4'h0, 32'(fld(15, 1, 1, 1, 1)));
    ok = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #2; if (pwm_out[0] !== 1'b1) ok = 1'b0;
    end
    check(ok, "R11 bypass overrides running setup", pwm_out[0], 1);
    @(negedge clk);
    wr(4'h0, 32'(fld(15, 0, 1, 1, 0)));
    hold_level(0, 1'b0, 20, "R11 leaving bypass returns to inactive");
  endtask

  task automatic t_indep();
    logic [31:0] d;
    int a, p;
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h0004_0002);
    wr(4'h8, 32'h0002_0001);
    @(negedge clk);
    wr(4'h0, 32'(fld(15, 1, 1, 1, 0)) | (32'(fld(15, 1, 1, 1, 0)) << 15));
    measure(0, 1'b1, a, p);
    check(a == 2 && p == 5, "R12 channel 0 timing", p, 5);
    measure(1, 1'b1, a, p);
    check(a == 1 && p == 3, "R12 channel 1 timing", p, 3);
    wr(4'h8, 32'h0005_0002);
    rd(4'h0, d);
    check(d[29:28] == 2'b10, "R12 busy only on written channel", d[29:28], 2'b10);
  endtask

  initial begin
    t_reset();
    t_layout();
    t_basic();
    t_div(15, 1);
    t_div(0, 120);
    t_div(2, 240);
    t_div(8, 12000);
    t_invalid();
    t_gate();
    t_pol();
    t_duty_edges();
    t_shadow();
    t_collide();
    t_bypass();
    t_indep();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule